// File: doc/BRIEF.md
# Codec Register Access Command Port

This block gives a host a pair of 32-bit memory-mapped words for reaching the 16-bit control registers of an external audio codec over a serial link. The host writes a command word that carries a direction bit, a 7-bit codec register number and, for writes, a 16-bit value. The block marks the command pending and offers it to a slot-based serializer over a valid/ready handshake. The pending flag drops when the serializer takes the command.

When a read command has been taken, the block remembers its register number. The serializer later returns the codec's answer as a one-cycle strobe with the register number and 16 bits of data. A matching answer lands in the status word and sets a sticky valid flag and a "new" flag. The first host read of the status word clears the "new" flag.

Command handshake rules: `cmd_valid` rises the cycle after an accepted host write and holds with stable payload until a cycle in which `cmd_ready` is high. The transfer happens on that clock edge, and `cmd_valid` is low in the next cycle. The serializer may hold `cmd_ready` low for any length of time. The response strobe has no back-pressure.

Top module: `codec_reg_port`

## Requirements
- R1: After reset the command word reads 0, the status word reads 0, and `cmd_valid` is low.
- R2: A host write at offset 0x0C while no command is pending loads the command. Readback at 0x0C then returns write bits 31:24 in bits 31:24 and write bits 15:0 in bits 15:0, with bit 16 (pending) set and bits 23:17 zero.
- R3: A host write at offset 0x0C while bit 16 is set is ignored, and the command readback is unchanged.
- R4: `cmd_valid` mirrors the pending bit. `cmd_read` is command bit 31 (1 = read), `cmd_index` is bits 30:24 and `cmd_data` is bits 15:0. All three hold steady while `cmd_valid` is high and `cmd_ready` is low.
- R5: A cycle with `cmd_valid` and `cmd_ready` both high clears the pending bit in the next cycle.
- R6: A response strobe whose index equals that of the outstanding read places `rsp_data` in status bits 15:0 and sets bit 16 (valid) and bit 17 (new) in the next cycle.
- R7: A response strobe is ignored when its index differs from the outstanding read, when no read is outstanding, or after a write-direction command.
- R8: A host read at offset 0x08 clears status bit 17 in the next cycle, while bit 16 and the data stay as they were.
- R9: When a host status read and an accepted response fall in the same cycle, the host sees the old status, and the new data arrives with bit 17 set.
- R10: Host accesses at any other offset read 0 and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | ADDR_W | Byte offset within the audio window |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for `host_addr` (combinational) |
| cmd_valid | output | 1 | Command offered to serializer |
| cmd_ready | input | 1 | Serializer takes the command |
| cmd_index | output | 7 | Codec register number |
| cmd_read | output | 1 | 1 = read command |
| cmd_data | output | 16 | Value for a write command |
| rsp_strobe | input | 1 | One-cycle read-answer strobe |
| rsp_index | input | 7 | Register number of the answer |
| rsp_data | input | 16 | Answer data |

## Verification
Two events can meet in one cycle: the host reads the status word and a matching codec answer arrives. The two make opposite demands on the "new" flag. The bench forces the collision by raising `host_rd` at 0x08 and `rsp_strobe` in the same cycle. It checks that the value read is the old status and that the following status carries the new data with the flag set. A second overlap, a host command write in the same cycle as the handshake that retires the pending command, is judged by the busy-write property: the late write must be dropped.

// File: rtl/crp_pkg.sv
package crp_pkg;
  localparam int WORD_W   = 32;
  localparam int IDX_W    = 7;
  localparam int VAL_W    = 16;
  localparam int DIR_BIT  = 31;
  localparam int IDX_LSB  = 24;
  localparam int BUSY_BIT = 16;
  localparam int NEW_BIT  = 17;

  typedef struct packed {
    logic             rd;
    logic [IDX_W-1:0] idx;
    logic [VAL_W-1:0] val;
  } codec_cmd_t;
endpackage

// File: rtl/crp_host_decode.sv
module crp_host_decode
  import crp_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] CMD_OFS  = 'h0C,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h08
) (
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [WORD_W-1:0] cmd_word,
  input  logic [WORD_W-1:0] stat_word,
  output logic              cmd_wr_hit,
  output logic              stat_rd_hit,
  output logic [WORD_W-1:0] host_rdata
);
  logic at_cmd, at_stat;

  assign at_cmd      = (host_addr == CMD_OFS);
  assign at_stat     = (host_addr == STAT_OFS);
  assign cmd_wr_hit  = host_wr & at_cmd;
  assign stat_rd_hit = host_rd & at_stat;

  always_comb begin
    if (at_cmd)       host_rdata = cmd_word;
    else if (at_stat) host_rdata = stat_word;
    else              host_rdata = '0;
  end
endmodule

// File: rtl/crp_cmd_slot.sv
module crp_cmd_slot
  import crp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WORD_W-1:0] wr_word,
  input  logic             cmd_ready,
  input  logic             rsp_take,
  output logic             pending,
  output codec_cmd_t       cmd,
  output logic             rd_wait,
  output logic [IDX_W-1:0] rd_wait_idx
);
  logic fire;
  logic unused_mid;

  assign fire       = pending & cmd_ready;
  assign unused_mid = ^wr_word[IDX_LSB-1:BUSY_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending     <= 1'b0;
      cmd         <= '0;
      rd_wait     <= 1'b0;
      rd_wait_idx <= '0;
    end else begin
      if (rsp_take) rd_wait <= 1'b0;
      if (fire) begin
        pending <= 1'b0;
        if (cmd.rd) begin
          rd_wait     <= 1'b1;
          rd_wait_idx <= cmd.idx;
        end
      end else if (load && !pending) begin
        pending <= 1'b1;
        cmd.rd  <= wr_word[DIR_BIT];
        cmd.idx <= wr_word[DIR_BIT-1:IDX_LSB];
        cmd.val <= wr_word[VAL_W-1:0];
      end
    end
  end
endmodule

// File: rtl/crp_status_slot.sv
module crp_status_slot
  import crp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rsp_strobe,
  input  logic [IDX_W-1:0] rsp_index,
  input  logic [VAL_W-1:0] rsp_data,
  input  logic             rd_wait,
  input  logic [IDX_W-1:0] rd_wait_idx,
  input  logic             stat_rd_hit,
  output logic             rsp_take,
  output logic [VAL_W-1:0] stat_data,
  output logic             stat_valid,
  output logic             stat_new
);
  assign rsp_take = rsp_strobe & rd_wait & (rsp_index == rd_wait_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_data  <= '0;
      stat_valid <= 1'b0;
      stat_new   <= 1'b0;
    end else if (rsp_take) begin
      stat_data  <= rsp_data;
      stat_valid <= 1'b1;
      stat_new   <= 1'b1;
    end else if (stat_rd_hit) begin
      stat_new <= 1'b0;
    end
  end
endmodule

// File: rtl/codec_reg_port.sv
module codec_reg_port
  import crp_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] CMD_OFS  = 'h0C,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [6:0]        cmd_index,
  output logic              cmd_read,
  output logic [15:0]       cmd_data,
  input  logic              rsp_strobe,
  input  logic [6:0]        rsp_index,
  input  logic [15:0]       rsp_data
);
  localparam int GAP_W = IDX_LSB - BUSY_BIT - 1;
  localparam int TOP_W = WORD_W - NEW_BIT - 1;

  logic             cmd_wr_hit, stat_rd_hit;
  logic             pending, rd_wait, rsp_take;
  logic [IDX_W-1:0] rd_wait_idx;
  codec_cmd_t       cmd;
  logic [VAL_W-1:0] stat_data;
  logic             stat_valid, stat_new;
  logic [WORD_W-1:0] cmd_word, stat_word;

  assign cmd_word  = {cmd.rd, cmd.idx, {GAP_W{1'b0}}, pending, cmd.val};
  assign stat_word = {{TOP_W{1'b0}}, stat_new, stat_valid, stat_data};

  assign cmd_valid = pending;
  assign cmd_index = cmd.idx;
  assign cmd_read  = cmd.rd;
  assign cmd_data  = cmd.val;

  crp_host_decode #(.ADDR_W(ADDR_W), .CMD_OFS(CMD_OFS), .STAT_OFS(STAT_OFS)) u_dec (
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_addr  (host_addr),
    .cmd_word   (cmd_word),
    .stat_word  (stat_word),
    .cmd_wr_hit (cmd_wr_hit),
    .stat_rd_hit(stat_rd_hit),
    .host_rdata (host_rdata)
  );

  crp_cmd_slot u_cmd (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (cmd_wr_hit),
    .wr_word    (host_wdata),
    .cmd_ready  (cmd_ready),
    .rsp_take   (rsp_take),
    .pending    (pending),
    .cmd        (cmd),
    .rd_wait    (rd_wait),
    .rd_wait_idx(rd_wait_idx)
  );

  crp_status_slot u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .rsp_strobe (rsp_strobe),
    .rsp_index  (rsp_index),
    .rsp_data   (rsp_data),
    .rd_wait    (rd_wait),
    .rd_wait_idx(rd_wait_idx),
    .stat_rd_hit(stat_rd_hit),
    .rsp_take   (rsp_take),
    .stat_data  (stat_data),
    .stat_valid (stat_valid),
    .stat_new   (stat_new)
  );
endmodule

// File: rtl/crp_checker.sv
module crp_checker #(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] CMD_OFS  = 'h0C,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h08
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr,
  input logic              host_rd,
  input logic [ADDR_W-1:0] host_addr,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [6:0]        cmd_index,
  input logic              cmd_read,
  input logic [15:0]       cmd_data,
  input logic              stat_valid,
  input logic              stat_new,
  input logic              stat_take
);
  logic wr_cmd, rd_stat;
  assign wr_cmd  = host_wr && (host_addr == CMD_OFS);
  assign rd_stat = host_rd && (host_addr == STAT_OFS);

  a_r2_load_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && !cmd_valid) |=> cmd_valid);

  a_r3_busy_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && cmd_valid) |=> ($stable(cmd_index) && $stable(cmd_data) && $stable(cmd_read)));

  a_r4_hold_under_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_index) && $stable(cmd_data) && $stable(cmd_read)));

  a_r5_handshake_retires: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_valid);

  a_r6_answer_flags: assert property (@(posedge clk) disable iff (!rst_n)
    stat_take |=> (stat_valid && stat_new));

  a_r8_read_clears_new: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !stat_take) |=> !stat_new);

  a_r8_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |=> stat_valid);

  a_r9_answer_beats_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && stat_take) |=> stat_new);
endmodule

bind codec_reg_port crp_checker #(.ADDR_W(ADDR_W), .CMD_OFS(CMD_OFS), .STAT_OFS(STAT_OFS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .host_wr   (host_wr),
  .host_rd   (host_rd),
  .host_addr (host_addr),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_index (cmd_index),
  .cmd_read  (cmd_read),
  .cmd_data  (cmd_data),
  .stat_valid(stat_valid),
  .stat_new  (stat_new),
  .stat_take (rsp_take)
);

// File: tb/codec_reg_port_bench.sv
module codec_reg_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0]  host_addr = 8'h00;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        cmd_valid, cmd_read;
  logic        cmd_ready = 1'b0;
  logic [6:0]  cmd_index;
  logic [15:0] cmd_data;
  logic        rsp_strobe = 1'b0;
  logic [6:0]  rsp_index = '0;
  logic [15:0] rsp_data = '0;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  codec_reg_port u_codec_reg_port (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_index(cmd_index),
    .cmd_read(cmd_read), .cmd_data(cmd_data), .rsp_strobe(rsp_strobe),
    .rsp_index(rsp_index), .rsp_data(rsp_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(posedge clk); #1 host_wr = 1'b0;
  endtask

  task automatic host_read(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk); host_rd = 1'b1; host_addr = a;
    #1 v = host_rdata;
    @(posedge clk); #1 host_rd = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk); host_addr = a; #1 v = host_rdata;
  endtask

  task automatic take_cmd();
    @(negedge clk); cmd_ready = 1'b1;
    @(posedge clk); #1 cmd_ready = 1'b0;
  endtask

  task automatic answer(input logic [6:0] i, input logic [15:0] d);
    @(negedge clk); rsp_strobe = 1'b1; rsp_index = i; rsp_data = d;
    @(posedge clk); #1 rsp_strobe = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    peek(8'h0C, v); chk("R1 command word", v, 32'h0);
    peek(8'h08, v); chk("R1 status word", v, 32'h0);
    chk("R1 cmd_valid", {31'b0, cmd_valid}, 32'h0);
  endtask

  task automatic t_load();
    logic [31:0] v;
    host_write(8'h0C, 32'h12AB_5678);
    peek(8'h0C, v); chk("R2 readback masked with busy", v, 32'h1201_5678);
    chk("R4 cmd_valid", {31'b0, cmd_valid}, 32'h1);
    chk("R4 cmd_index", {25'b0, cmd_index}, 32'h12);
    chk("R4 cmd_read", {31'b0, cmd_read}, 32'h0);
    chk("R4 cmd_data", {16'b0, cmd_data}, 32'h5678);
  endtask

  task automatic t_busy();
    logic [31:0] v;
    host_write(8'h0C, 32'hB400_1111);
    peek(8'h0C, v); chk("R3 busy write ignored", v, 32'h1201_5678);
    repeat (3) @(posedge clk);
    #1 chk("R4 data held under back-pressure", {15'b0, cmd_valid, cmd_data}, 32'h0001_5678);
  endtask

  task automatic t_handshake();
    logic [31:0] v;
    take_cmd();
    chk("R5 cmd_valid low after handshake", {31'b0, cmd_valid}, 32'h0);
    peek(8'h0C, v); chk("R5 busy bit cleared", v, 32'h1200_5678);
  endtask

  task automatic t_read_answer();
    logic [31:0] v;
    host_write(8'h0C, 32'h8500_0000);
    chk("R4 read direction", {24'b0, cmd_read, cmd_index}, 32'h85);
    take_cmd();
    answer(7'h06, 16'hBEEF);
    peek(8'h08, v); chk("R7 mismatched index ignored", v, 32'h0);
    answer(7'h05, 16'hCAFE);
    peek(8'h08, v); chk("R6 answer stored with flags", v, 32'h0003_CAFE);
  endtask

  task automatic t_read_clears_new();
    logic [31:0] v;
    host_read(8'h08, v); chk("R8 first read sees new", v, 32'h0003_CAFE);
    peek(8'h08, v); chk("R8 new cleared, valid kept", v, 32'h0001_CAFE);
  endtask

  task automatic t_collision();
    logic [31:0] v;
    host_write(8'h0C, 32'hA200_0000);
    take_cmd();
    @(negedge clk);
    host_rd = 1'b1; host_addr = 8'h08;
    rsp_strobe = 1'b1; rsp_index = 7'h22; rsp_data = 16'h1234;
    #1 v = host_rdata;
    @(posedge clk); #1 host_rd = 1'b0; rsp_strobe = 1'b0;
    chk("R9 read returns old status", v, 32'h0001_CAFE);
    peek(8'h08, v); chk("R9 new data with new flag", v, 32'h0003_1234);
  endtask

  task automatic t_stale();
    logic [31:0] v;
    host_read(8'h08, v);
    answer(7'h22, 16'h9999);
    peek(8'h08, v); chk("R7 no outstanding read", v, 32'h0001_1234);
    host_write(8'h0C, 32'h2200_7777);
    take_cmd();
    answer(7'h22, 16'h8888);
    peek(8'h08, v); chk("R7 write command makes no read", v, 32'h0001_1234);
  endtask

  task automatic t_other();
    logic [31:0] v;
    host_write(8'h10, 32'hFFFF_FFFF);
    chk("R10 stray write no command", {31'b0, cmd_valid}, 32'h0);
    peek(8'h0C, v); chk("R10 command unchanged", v, 32'h2200_7777);
    host_read(8'h10, v); chk("R10 stray read zero", v, 32'h0);
    peek(8'h08, v); chk("R10 status unchanged", v, 32'h0001_1234);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_load();
    t_busy();
    t_handshake();
    t_read_answer();
    t_read_clears_new();
    t_collision();
    t_stale();
    t_other();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule